// File: doc/BRIEF.md
# Chip-Select Output Controller

This block drives a bank of chip-select pins for a serial host controller. A configuration register holds two fields per pin: a select-mode flag that hands the pin to this block, and a polarity flag that flips the pin for devices whose select is active high. A write-only fast register raises or lowers any set of stored select levels in one write, with no read-modify-write. The stored levels can be read back through a status register.

A small command stream drives individual selects by logical number. Logical numbers start at a base index, so logical select k drives pin k minus the base. A command to assert a select always drives the stored bit low, so with the polarity flag the pin reaches its active level. A command to deassert drives the stored bit high. The command port is valid/ready. A register write holds `cmd_ready` low for that cycle, and a stalled command stays pending until it is accepted.

Top module: `cs_select_ctrl`

## Requirements
- R1: After reset every stored level is 1, every mode and polarity flag is 0, and every pin is high.
- R2: A write to address 0 loads the configuration: bits 15:8 are the mode flags for pins 7..0 and bits 7:0 are the polarity flags. A read of address 0 returns the value written.
- R3: A write to address 1 with bit 8+n set makes stored level n equal to 1 from the next cycle.
- R4: A write to address 1 with bit n set makes stored level n equal to 0. When bits n and 8+n are both 1, the clear wins. Pins whose two bits are both 0 keep their stored level.
- R5: Pin n equals stored level n XOR polarity flag n when mode flag n is 1. When mode flag n is 0, pin n is held at the idle level 1.
- R6: A read of address 2 returns the stored levels in bits 7:0 and 0 in bits 15:8. A read of address 1, or of any unmapped address, returns 0.
- R7: An accepted command with `cmd_num` = k, where base ≤ k < base+8 and base = 1, acts on stored level k−base. It sets that level to 0 when `cmd_assert` = 1 and to 1 when `cmd_assert` = 0. A command with k out of that range changes nothing.
- R8: `cmd_ready` is 0 in any cycle with `wr_en` = 1 and is 1 otherwise. A command takes effect only when `cmd_valid` and `cmd_ready` are both 1. Each accepted command changes at most one stored level.
- R9: A write to any address other than 0 or 1 changes neither the configuration nor the stored levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Read data for `rd_addr` (combinational) |
| cmd_valid | input | 1 | Select command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_num | input | 4 | Logical select number |
| cmd_assert | input | 1 | 1 asserts the select, 0 releases it |
| cs_pins | output | 8 | Chip-select pin levels |

## Verification
A fast register write and a select command can arrive in the same cycle, and both target the same stored levels. The bench provokes this in directed cases and in random cycles that raise `wr_en` and `cmd_valid` together. It checks that `cmd_ready` drops in that cycle, that the stored levels reflect only the write, and that the held command takes effect one cycle after the write strobe goes away. A reference model applies writes and accepted commands in the same order, and the pins and status readback are compared with it every cycle.

// File: rtl/cs_ctrl_pkg.sv
package cs_ctrl_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_FAST = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int unsigned CFG_OFS  = 0;
  localparam int unsigned FAST_OFS = 1;
  localparam int unsigned STAT_OFS = 2;
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import cs_ctrl_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 4,
  localparam int DATA_W = 2 * NPINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NPINS-1:0]  stored,
  output logic [DATA_W-1:0] rd_data,
  output logic [NPINS-1:0]  mode_q,
  output logic [NPINS-1:0]  inv_q,
  output logic              fast_we,
  output logic [NPINS-1:0]  fast_set,
  output logic [NPINS-1:0]  fast_clr
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] A_FAST = ADDR_W'(FAST_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == A_CFG)       return SEL_CFG;
    else if (a == A_FAST) return SEL_FAST;
    else if (a == A_STAT) return SEL_STAT;
    else                  return SEL_NONE;
  endfunction

  reg_sel_e wsel, rsel;
  assign wsel = decode(wr_addr);
  assign rsel = decode(rd_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      inv_q  <= '0;
    end else if (wr_en && wsel == SEL_CFG) begin
      mode_q <= wr_data[DATA_W-1:NPINS];
      inv_q  <= wr_data[NPINS-1:0];
    end
  end

  assign fast_we  = wr_en && (wsel == SEL_FAST);
  assign fast_set = wr_data[DATA_W-1:NPINS];
  assign fast_clr = wr_data[NPINS-1:0];

  always_comb begin
    unique case (rsel)
      SEL_CFG:  rd_data = {mode_q, inv_q};
      SEL_STAT: rd_data = {{NPINS{1'b0}}, stored};
      default:  rd_data = '0;
    endcase
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wsel == SEL_CFG) |=> $stable({mode_q, inv_q})) // R9
    else $error("config changed without a config write");
endmodule

// File: rtl/cs_level_store.sv
module cs_level_store #(
  parameter int NPINS   = 8,
  parameter int NUM_W   = 4,
  parameter int CS_BASE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_we,
  input  logic [NPINS-1:0] fast_set,
  input  logic [NPINS-1:0] fast_clr,
  input  logic             cmd_fire,
  input  logic [NUM_W-1:0] cmd_num,
  input  logic             cmd_assert,
  output logic [NPINS-1:0] stored
);
  localparam int IW = NUM_W + 1;
  localparam logic [IW-1:0] BASE_V  = IW'(CS_BASE);
  localparam logic [IW-1:0] LIMIT_V = IW'(CS_BASE + NPINS);

  logic [IW-1:0]    num_ext, pin_idx;
  logic             in_range;
  logic [NPINS-1:0] hit, nxt;

  assign num_ext  = {1'b0, cmd_num};
  assign in_range = (num_ext >= BASE_V) && (num_ext < LIMIT_V);
  assign pin_idx  = num_ext - BASE_V;

  for (genvar n = 0; n < NPINS; n++) begin : g_hit
    assign hit[n] = in_range && (pin_idx == IW'(n));
  end

  always_comb begin
    nxt = stored;
    if (fast_we)
      nxt = (stored | fast_set) & ~fast_clr;
    else if (cmd_fire)
      nxt = cmd_assert ? (stored & ~hit) : (stored | hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stored <= '1;
    else        stored <= nxt;
  end

  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    fast_we |=> ((stored & $past(fast_set & ~fast_clr)) == $past(fast_set & ~fast_clr))) // R3
    else $error("fast set not applied");
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fast_we |=> ((stored & $past(fast_clr)) == '0)) // R4
    else $error("fast clear not applied");
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_we && !cmd_fire) |=> $stable(stored)) // R9
    else $error("stored levels moved with no write or command");
  AST_ONE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !fast_we) |=> ($countones(stored ^ $past(stored)) <= 1)) // R7
    else $error("command touched more than one level");
endmodule

// File: rtl/cs_pin_drive.sv
module cs_pin_drive #(
  parameter int   NPINS      = 8,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic [NPINS-1:0] stored,
  input  logic [NPINS-1:0] mode_q,
  input  logic [NPINS-1:0] inv_q,
  output logic [NPINS-1:0] pins
);
  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    assign pins[n] = mode_q[n] ? (stored[n] ^ inv_q[n]) : IDLE_LEVEL;
  end
endmodule

// File: rtl/cs_select_ctrl.sv
module cs_select_ctrl #(
  parameter int NPINS   = 8,
  parameter int ADDR_W  = 4,
  parameter int NUM_W   = 4,
  parameter int CS_BASE = 1,
  localparam int DATA_W = 2 * NPINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [NUM_W-1:0]  cmd_num,
  input  logic              cmd_assert,
  output logic [NPINS-1:0]  cs_pins
);
  logic [NPINS-1:0] stored, mode_q, inv_q, fast_set, fast_clr;
  logic             fast_we, cmd_fire;

  assign cmd_ready = !wr_en;
  assign cmd_fire  = cmd_valid && cmd_ready;

  cs_cfg_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .stored(stored), .rd_data(rd_data),
    .mode_q(mode_q), .inv_q(inv_q), .fast_we(fast_we),
    .fast_set(fast_set), .fast_clr(fast_clr)
  );

  cs_level_store #(.NPINS(NPINS), .NUM_W(NUM_W), .CS_BASE(CS_BASE)) store_i (
    .clk(clk), .rst_n(rst_n), .fast_we(fast_we), .fast_set(fast_set),
    .fast_clr(fast_clr), .cmd_fire(cmd_fire), .cmd_num(cmd_num),
    .cmd_assert(cmd_assert), .stored(stored)
  );

  cs_pin_drive #(.NPINS(NPINS), .IDLE_LEVEL(1'b1)) drive_i (
    .stored(stored), .mode_q(mode_q), .inv_q(inv_q), .pins(cs_pins)
  );

  AST_WR_STALLS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cmd_ready) // R8
    else $error("command accepted during a register write");
  AST_RESET_LEVELS: assert property (@(posedge clk)
    $rose(rst_n) |-> (stored == '1 && cs_pins == '1)) // R1
    else $error("levels not high out of reset");
endmodule

// File: tb/cs_select_ctrl_tb.sv
module cs_select_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_num = '0;
  logic        cmd_assert = 1'b0;
  logic [7:0]  cs_pins;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] m_stored = 8'hFF, m_mode = 8'h00, m_inv = 8'h00;

  always #10 clk = ~clk;

  cs_select_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_num(cmd_num),
    .cmd_assert(cmd_assert), .cs_pins(cs_pins)
  );

  function automatic logic [7:0] exp_pins();
    return (m_mode & (m_stored ^ m_inv)) | ~m_mode;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [3:0] a);
    if (a == 4'd0) return {m_mode, m_inv};
    if (a == 4'd2) return {8'h00, m_stored};
    return 16'h0000;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    if (wr_en) begin
      if (wr_addr == 4'd0) begin m_mode = wr_data[15:8]; m_inv = wr_data[7:0]; end
      else if (wr_addr == 4'd1) m_stored = (m_stored | wr_data[15:8]) & ~wr_data[7:0];
    end else if (cmd_valid && cmd_num >= 4'd1 && cmd_num <= 4'd8) begin
      if (cmd_assert) m_stored[cmd_num - 4'd1] = 1'b0;
      else            m_stored[cmd_num - 4'd1] = 1'b1;
    end
  endtask

  task automatic cycle();
    model_step();
    @(negedge clk);
    wr_en = 1'b0; cmd_valid = 1'b0;
  endtask

  task automatic do_write(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cycle();
  endtask

  task automatic do_cmd(input logic [3:0] k, input logic act);
    cmd_valid = 1'b1; cmd_num = k; cmd_assert = act;
    cycle();
  endtask

  task automatic check_state(input string req);
    check(req, {8'h00, cs_pins}, {8'h00, exp_pins()});
    rd_addr = 4'd2; #1;
    check(req, rd_data, exp_rd(4'd2));
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pins", {8'h00, cs_pins}, 16'h00FF);
    rd_addr = 4'd0; #1; check("R1 cfg", rd_data, 16'h0000);
    rd_addr = 4'd2; #1; check("R1 stat", rd_data, 16'h00FF);
    // R2 configuration write and readback
    do_write(4'd0, 16'h0F05);
    rd_addr = 4'd0; #1; check("R2 cfg readback", rd_data, 16'h0F05);
    check_state("R5 pins after cfg");
    // R4 clear all
    do_write(4'd1, 16'h00FF);
    check_state("R4 clear all");
    // R3 set pin 2
    do_write(4'd1, 16'h0400);
    check_state("R3 set pin2");
    // R4 set and clear together: clear wins
    do_write(4'd1, 16'h0C0C);
    check_state("R4 clear wins");
    // R6 fast register and unmapped read zero
    rd_addr = 4'd1; #1; check("R6 fast reads zero", rd_data, 16'h0000);
    rd_addr = 4'd7; #1; check("R6 unmapped reads zero", rd_data, 16'h0000);
    // R9 write to unmapped address ignored
    do_write(4'd5, 16'hFFFF);
    check_state("R9 unmapped write");
    rd_addr = 4'd0; #1; check("R9 cfg kept", rd_data, 16'h0F05);
    // R7 commands
    do_write(4'd1, 16'hFF00);
    do_cmd(4'd1, 1'b1);
    check_state("R7 assert logical 1 -> pin0");
    do_cmd(4'd8, 1'b1);
    check_state("R7 assert logical 8 -> pin7");
    do_cmd(4'd0, 1'b1);
    check_state("R7 below base ignored");
    do_cmd(4'd9, 1'b1);
    check_state("R7 above range ignored");
    do_cmd(4'd1, 1'b0);
    check_state("R7 release pin0");
    // R8 write and command in the same cycle
    wr_en = 1'b1; wr_addr = 4'd1; wr_data = 16'h0010;
    cmd_valid = 1'b1; cmd_num = 4'd3; cmd_assert = 1'b1; #1;
    check("R8 ready low during write", {15'h0, cmd_ready}, 16'h0000);
    model_step();
    @(negedge clk);
    wr_en = 1'b0;
    check_state("R8 only write applied");
    #1; check("R8 ready back", {15'h0, cmd_ready}, 16'h0001);
    cycle();
    check_state("R8 held command applied");
    // random mix of writes and commands
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      wr_en = r[0] & r[1];
      wr_addr = r[3] ? {2'b00, r[5:4]} : r[7:4];
      wr_data = r[31:16];
      cmd_valid = r[2];
      cmd_num = r[11:8];
      cmd_assert = r[12];
      #1;
      if (wr_en && cmd_valid)
        check("R8 random stall", {15'h0, cmd_ready}, 16'h0000);
      cycle();
      check_state("R5 random");
      rd_addr = 4'd0; #1; check("R2 random cfg", rd_data, exp_rd(4'd0));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule